// File: doc/BRIEF.md
# UART Command Byte Decoder

This block takes the byte written to a UART's command register and splits it into three fields that act together: a general command (low-level resets and break handling), a transmitter command and a receiver command. It holds the transmitter-enable, transmitter-ready and receiver-enable state. Actions that other parts of the UART must carry out leave the block as one-cycle pulses: rewinding the mode-register pointer, flushing the receive FIFO, forcing the transmit holding buffer empty, clearing the break-change interrupt, and sending the byte that waits in the transmit buffer.

The fields take effect in a fixed order. The general field goes first, then the transmitter field, then the receiver field. So a byte that resets the transmitter and also enables it leaves the transmitter enabled. Reserved transmitter or receiver codes change no state. They set a sticky error flag that only reset clears. Break start/stop and error-status reset are accepted and do nothing.

Top module: `uart_cmd_decoder`

## Requirements
- R1: During and right after reset, tx_enabled, rx_enabled, tx_ready, cmd_error and all pulse outputs are 0.
- R2: The general field is cmd_byte[6:4], the transmitter field is cmd_byte[3:2] and the receiver field is cmd_byte[1:0]. Bit 7 has no effect.
- R3: General code 1 pulses mode_ptr_rst and code 5 pulses brk_int_clr. Codes 0, 4, 6 and 7 cause no pulse and no state change.
- R4: General code 2 clears rx_enabled and pulses rx_flush.
- R5: General code 3 clears tx_enabled and tx_ready and pulses tx_force_empty.
- R6: Transmitter code 1 sets tx_enabled and tx_ready. Code 2 clears both. Code 0 leaves them unchanged.
- R7: Receiver code 1 sets rx_enabled, code 2 clears it, and code 0 leaves it unchanged.
- R8: The general field acts before the transmitter field, and the transmitter field before the receiver field. Reset-transmitter with transmitter enable leaves tx_enabled at 1. Reset-receiver with receiver enable leaves rx_enabled at 1.
- R9: Transmitter code 1 pulses tx_send when tx_pending is 1, unless general code 3 is in the same byte. No other code pulses tx_send.
- R10: Transmitter or receiver code 3 sets cmd_error, which stays at 1 until reset. A reserved code changes no enable or ready state.
- R11: Each pulse is high for exactly the one cycle after the clock edge that samples cmd_wr high. When cmd_wr is low, no pulse fires and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| tx_pending | input | 1 | A byte waits in the transmit holding buffer |
| tx_enabled | output | 1 | Transmitter enabled |
| rx_enabled | output | 1 | Receiver enabled |
| tx_ready | output | 1 | Transmitter ready for a new byte |
| mode_ptr_rst | output | 1 | Pulse: rewind the mode-register pointer |
| rx_flush | output | 1 | Pulse: empty the receive FIFO |
| tx_force_empty | output | 1 | Pulse: mark the transmit buffer empty |
| brk_int_clr | output | 1 | Pulse: clear the break-change interrupt |
| tx_send | output | 1 | Pulse: send the pending transmit byte |
| cmd_error | output | 1 | Sticky: a reserved code was seen |

## Verification
The bench aims at bytes that combine fields. A design that applied the fields in the wrong order would end a reset-transmitter-plus-enable byte with the transmitter off, or a reset-receiver-plus-enable byte with the receiver off. A design that sent the pending byte during a transmitter reset would issue tx_send together with tx_force_empty. It also sends reserved codes: a wrong design would toggle an enable or fail to keep cmd_error set. It sends bytes with only bit 7 set and stretches with the strobe low: a wrong design would react to the spare bit or stretch a pulse past one cycle.

// File: rtl/uart_cmd_pkg.sv
// Shared field codes, decoded-command type and pulse indices for the
// UART command decoder. Assumes an 8-bit command byte.
package uart_cmd_pkg;
    localparam int CMD_W    = 8;
    localparam int RX_LSB   = 0;
    localparam int TX_LSB   = 2;
    localparam int MISC_LSB = 4;
    localparam int MISC_W   = 3;
    localparam int EN_W     = 2;

    typedef enum logic [MISC_W-1:0] {
        MISC_NOP, MISC_MODE_PTR, MISC_RX_RESET, MISC_TX_RESET,
        MISC_ERR_RESET, MISC_BRK_CLR, MISC_BRK_START, MISC_BRK_STOP
    } misc_op_e;

    typedef enum logic [EN_W-1:0] {EN_NOP, EN_ON, EN_OFF, EN_RSVD} en_op_e;

    typedef struct packed {
        misc_op_e misc;
        en_op_e   tx;
        en_op_e   rx;
    } cmd_fields_t;

    localparam int P_MODE  = 0;
    localparam int P_RXFL  = 1;
    localparam int P_TXFL  = 2;
    localparam int P_BRK   = 3;
    localparam int P_SEND  = 4;
    localparam int PULSE_N = 5;
endpackage

// File: rtl/cmd_field_split.sv
// Splits a command byte into its general, transmitter and receiver fields.
// Assumes the byte is at least MISC_LSB+MISC_W bits wide. Bits above the
// general field are spare and are dropped.
module cmd_field_split
    import uart_cmd_pkg::*;
#(
    parameter int BYTE_W = CMD_W
) (
    input  logic [BYTE_W-1:0] cmd,
    output cmd_fields_t       fields
);
    localparam int TOP_USED = MISC_LSB + MISC_W;

    logic unused_spare;

    // Field extraction at the fixed bit positions.
    always_comb begin
        fields.misc = misc_op_e'(cmd[MISC_LSB +: MISC_W]);
        fields.tx   = en_op_e'(cmd[TX_LSB +: EN_W]);
        fields.rx   = en_op_e'(cmd[RX_LSB +: EN_W]);
    end

    // Spare bits are collected so they are visibly unused.
    assign unused_spare = ^cmd[BYTE_W-1:TOP_USED];
endmodule

// File: rtl/cmd_apply.sv
// Applies one decoded command to the current enable state, in order:
// general field, then transmitter field, then receiver field. Pure
// combinational; the caller registers the results.
module cmd_apply
    import uart_cmd_pkg::*;
(
    input  cmd_fields_t        fields,
    input  logic               tx_pending,
    input  logic               cur_tx_en,
    input  logic               cur_tx_rdy,
    input  logic               cur_rx_en,
    output logic               nxt_tx_en,
    output logic               nxt_tx_rdy,
    output logic               nxt_rx_en,
    output logic [PULSE_N-1:0] pulses,
    output logic               rsvd_seen
);
    logic buf_pending;

    // Staged update: each field sees the result of the one before it.
    always_comb begin
        nxt_tx_en   = cur_tx_en;
        nxt_tx_rdy  = cur_tx_rdy;
        nxt_rx_en   = cur_rx_en;
        pulses      = '0;
        rsvd_seen   = 1'b0;
        buf_pending = tx_pending;

        unique case (fields.misc)
            MISC_MODE_PTR: pulses[P_MODE] = 1'b1;
            MISC_RX_RESET: begin
                nxt_rx_en      = 1'b0;
                pulses[P_RXFL] = 1'b1;
            end
            MISC_TX_RESET: begin
                nxt_tx_en      = 1'b0;
                nxt_tx_rdy     = 1'b0;
                buf_pending    = 1'b0;
                pulses[P_TXFL] = 1'b1;
            end
            MISC_BRK_CLR:  pulses[P_BRK] = 1'b1;
            default: ;
        endcase

        unique case (fields.tx)
            EN_ON: begin
                nxt_tx_en      = 1'b1;
                nxt_tx_rdy     = 1'b1;
                pulses[P_SEND] = buf_pending;
            end
            EN_OFF: begin
                nxt_tx_en  = 1'b0;
                nxt_tx_rdy = 1'b0;
            end
            EN_RSVD: rsvd_seen = 1'b1;
            default: ;
        endcase

        unique case (fields.rx)
            EN_ON:   nxt_rx_en = 1'b1;
            EN_OFF:  nxt_rx_en = 1'b0;
            EN_RSVD: rsvd_seen = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cmd_pulse_reg.sv
// Registers a vector of action requests so each becomes a single-cycle
// pulse in the cycle after a command write. Assumes synchronous active-low reset.
module cmd_pulse_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] req,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One flop per action: capture on a write, otherwise drop to 0.
        always_ff @(posedge clk) begin
            if (!rst_n)    pulse[i] <= 1'b0;
            else if (load) pulse[i] <= req[i];
            else           pulse[i] <= 1'b0;
        end

        // R11
        pulse_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |-> $past(load));
        // R11
        pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse[i] && !load) |=> !pulse[i]);
    end
endmodule

// File: rtl/uart_cmd_decoder.sv
// Top of the UART command decoder. Holds the transmitter/receiver enable
// state and the sticky reserved-code flag. Drives action pulses one cycle
// after each command write. Assumes a synchronous active-low reset and one
// command byte per strobe cycle.
module uart_cmd_decoder
    import uart_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             tx_pending,
    output logic             tx_enabled,
    output logic             rx_enabled,
    output logic             tx_ready,
    output logic             mode_ptr_rst,
    output logic             rx_flush,
    output logic             tx_force_empty,
    output logic             brk_int_clr,
    output logic             tx_send,
    output logic             cmd_error
);
    cmd_fields_t        fields;
    logic               nxt_tx_en, nxt_tx_rdy, nxt_rx_en, rsvd_seen;
    logic [PULSE_N-1:0] req, pulse;

    cmd_field_split #(.BYTE_W(CMD_W)) u_split (
        .cmd    (cmd_byte),
        .fields (fields)
    );

    cmd_apply u_apply (
        .fields     (fields),
        .tx_pending (tx_pending),
        .cur_tx_en  (tx_enabled),
        .cur_tx_rdy (tx_ready),
        .cur_rx_en  (rx_enabled),
        .nxt_tx_en  (nxt_tx_en),
        .nxt_tx_rdy (nxt_tx_rdy),
        .nxt_rx_en  (nxt_rx_en),
        .pulses     (req),
        .rsvd_seen  (rsvd_seen)
    );

    cmd_pulse_reg #(.N(PULSE_N)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd_wr),
        .req   (req),
        .pulse (pulse)
    );

    // Enable/ready state: takes the staged result on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_enabled <= 1'b0;
            tx_ready   <= 1'b0;
            rx_enabled <= 1'b0;
        end else if (cmd_wr) begin
            tx_enabled <= nxt_tx_en;
            tx_ready   <= nxt_tx_rdy;
            rx_enabled <= nxt_rx_en;
        end
    end

    // Sticky error flag: set by any reserved field code, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cmd_error <= 1'b0;
        else if (cmd_wr && rsvd_seen)    cmd_error <= 1'b1;
    end

    assign mode_ptr_rst   = pulse[P_MODE];
    assign rx_flush       = pulse[P_RXFL];
    assign tx_force_empty = pulse[P_TXFL];
    assign brk_int_clr    = pulse[P_BRK];
    assign tx_send        = pulse[P_SEND];

    // R6
    tx_ready_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready == tx_enabled);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |=> cmd_error);
    // R3
    misc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_ptr_rst, rx_flush, tx_force_empty, brk_int_clr}));
    // R9
    send_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |-> (tx_enabled && !tx_force_empty));
    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> ($stable(tx_enabled) && $stable(rx_enabled)));
endmodule

// File: tb/sim_uart_cmd_decoder.sv
`timescale 1ns/1ps
module sim_uart_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       tx_pending = 1'b0;
    logic       tx_enabled, rx_enabled, tx_ready;
    logic       mode_ptr_rst, rx_flush, tx_force_empty, brk_int_clr, tx_send, cmd_error;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic m_tx = 0, m_rx = 0, m_err = 0;

    always #2.5 clk = ~clk;

    uart_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .tx_pending(tx_pending), .tx_enabled(tx_enabled), .rx_enabled(rx_enabled),
        .tx_ready(tx_ready), .mode_ptr_rst(mode_ptr_rst), .rx_flush(rx_flush),
        .tx_force_empty(tx_force_empty), .brk_int_clr(brk_int_clr),
        .tx_send(tx_send), .cmd_error(cmd_error)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected pulse vector {send,brk,txfl,rxfl,mode} for one byte.
    function automatic logic [4:0] exp_pulses(input logic [7:0] b, input logic pend);
        logic [2:0] g = b[6:4];
        logic [1:0] t = b[3:2];
        exp_pulses = {(t == 2'd1) && pend && (g != 3'd3), g == 3'd5, g == 3'd3,
                      g == 3'd2, g == 3'd1};
    endfunction

    function automatic logic [2:0] exp_state(input logic [7:0] b, input logic tx,
                                             input logic rx, input logic err);
        logic [2:0] g = b[6:4];
        logic [1:0] t = b[3:2];
        logic [1:0] r = b[1:0];
        if (g == 3'd2) rx = 0;
        if (g == 3'd3) tx = 0;
        if (t == 2'd1) tx = 1; else if (t == 2'd2) tx = 0; else if (t == 2'd3) err = 1;
        if (r == 2'd1) rx = 1; else if (r == 2'd2) rx = 0; else if (r == 2'd3) err = 1;
        exp_state = {tx, rx, err};
    endfunction

    task automatic check_outputs(input string req, input logic [4:0] ep);
        chk(req, "pulses", {tx_send, brk_int_clr, tx_force_empty, rx_flush, mode_ptr_rst}, ep);
        chk(req, "tx_enabled", tx_enabled, m_tx);
        chk(req, "tx_ready", tx_ready, m_tx);
        chk(req, "rx_enabled", rx_enabled, m_rx);
        chk(req, "cmd_error", cmd_error, m_err);
    endtask

    // Called at a negedge: drive a write, then check in the cycle after the edge.
    task automatic send_cmd(input string req, input logic [7:0] b, input logic pend);
        logic [4:0] ep = exp_pulses(b, pend);
        {m_tx, m_rx, m_err} = exp_state(b, m_tx, m_rx, m_err);
        cmd_wr = 1; cmd_byte = b; tx_pending = pend;
        @(negedge clk);
        cmd_wr = 0;
        check_outputs(req, ep);
    endtask

    task automatic idle(input string req, input logic [7:0] junk);
        cmd_byte = junk; tx_pending = 1;
        @(negedge clk);
        check_outputs(req, 5'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5179));
        repeat (3) @(negedge clk);
        check_outputs("R1", 5'd0);
        rst_n = 1;
        @(negedge clk);
        check_outputs("R1", 5'd0);

        // R3: general codes with quiet tx/rx fields
        for (int g = 0; g < 8; g++) send_cmd("R3", 8'(g << 4), 1'b0);
        idle("R11", 8'hFF);
        // R6, R7: enables and disables
        send_cmd("R6", 8'h04, 1'b0);
        send_cmd("R7", 8'h01, 1'b0);
        send_cmd("R4", 8'h20, 1'b0);
        send_cmd("R5", 8'h30, 1'b1);
        // R9: enable with pending byte sends it
        send_cmd("R9", 8'h04, 1'b1);
        send_cmd("R9", 8'h04, 1'b1);
        send_cmd("R6", 8'h08, 1'b1);
        // R8: reset tx + enable tx leaves tx on, no send
        send_cmd("R8", 8'h34, 1'b1);
        // R8: reset rx + enable rx leaves rx on
        send_cmd("R8", 8'h21, 1'b0);
        // R2: spare bit alone does nothing
        send_cmd("R2", 8'h80, 1'b1);
        send_cmd("R2", 8'hA8, 1'b0);
        // R11: strobe low stretch
        idle("R11", 8'h35);
        idle("R11", 8'h06);
        // R10: reserved codes
        send_cmd("R10", 8'h0C, 1'b1);
        send_cmd("R10", 8'h03, 1'b0);
        idle("R10", 8'h00);
        // R1: re-enter reset clears sticky error
        rst_n = 0; m_tx = 0; m_rx = 0; m_err = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_outputs("R1", 5'd0);
        send_cmd("R10", 8'h0D, 1'b0);

        // Random mix covering R2..R11
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) idle("R11", 8'($urandom));
            else send_cmd("R8", 8'($urandom), 1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule